// File: doc/BRIEF.md
# Pipelined Return-Address Tracker

This block is the instruction-address control path of a five-stage in-order pipeline: fetch, then four stage registers in front of decode, execute, memory and writeback. It holds the fetch PC. For each fetched instruction it computes the fall-through address as the fetch address plus that instruction's length. Instructions may have variable length, so the length comes in from the fetch side. The fall-through address travels beside its instruction through every stage register, together with a valid bit. A cleared valid bit marks a no-op.

A call resolves when it reaches execute. By then the fetch PC has moved past the two younger instructions, so the block does not push the live PC as the return address. It pushes the fall-through address that travelled with the call, then redirects fetch to the call target and squashes the younger work. A taken conditional branch resolves later, in memory. It redirects fetch, squashes everything younger, and takes precedence over a call in execute, because the call is itself younger than the branch. A stall freezes the pipeline. A branch that arrives during a stall is still acted on.

Top module: `pc_chain`

## Requirements
- R1: During reset the fetch PC is RESET_PC, all four stage valid bits (`vld_o` bit 0 = decode, bit 1 = execute, bit 2 = memory, bit 3 = writeback) are zero, and `ra_push_o` is low.
- R2: In a cycle with no stall and no redirect, the PC on the next edge becomes PC + `fetch_len_i`, and the fetched instruction enters the decode register as valid.
- R3: Each instruction's fall-through address (its fetch address plus its length) moves one stage per unstalled cycle. It shows on `ex_npc_o` while the instruction is in execute and on `wb_npc_o` while it is in writeback.
- R4: A valid call in execute with no stall and no branch taken in memory has three effects on the next edge. The PC is loaded with `ex_target_i`. `ra_push_o` is high for exactly one cycle. `ra_addr_o` carries the call's own fall-through address.
- R5: On such a call, the decode instruction and the instruction being fetched become no-ops. The call itself moves on into memory.
- R6: A valid taken branch in memory (`mem_taken_i`) with no stall redirects the PC to `mem_target_i` and squashes the instructions in execute and decode and the one being fetched. A call in execute during that cycle is squashed and pushes nothing.
- R7: With `stall_i` high and no branch taken in memory, the PC and every stage register hold, and a call in execute waits. It pushes nothing until the stall lifts.
- R8: A valid taken branch in memory during a stall still redirects the PC and clears the decode and execute valid bits. The memory and writeback stages hold.
- R9: `ex_call_i` is ignored when the execute stage is invalid, and `mem_taken_i` is ignored when the memory stage is invalid. Fetch continues sequentially and nothing is pushed.
- R10: Fall-through addresses follow the actual instruction length (1 to 15 bytes), not a fixed step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze PC and stage registers |
| fetch_len_i | input | LW | Length in bytes of the instruction at `pc_o` |
| ex_call_i | input | 1 | Instruction in execute is a call |
| ex_target_i | input | AW | Call target address |
| mem_taken_i | input | 1 | Instruction in memory is a taken branch |
| mem_target_i | input | AW | Branch target address |
| pc_o | output | AW | Current fetch PC |
| vld_o | output | NSTG | Stage valid bits: decode, execute, memory, writeback |
| ex_npc_o | output | AW | Fall-through address carried in execute |
| wb_npc_o | output | AW | Fall-through address carried in writeback |
| ra_push_o | output | 1 | One-cycle return-address push strobe |
| ra_addr_o | output | AW | Return address presented with the push |

## Verification
A stage register that carried the wrong fall-through address shows up at the ports. It gives a wrong `ex_npc_o` two cycles after fetch, a wrong `ra_addr_o` on the edge after the call reaches execute, and a wrong `wb_npc_o` two cycles after that. A valid bit that was not cleared on a flush shows as a set bit in `vld_o` in the cycle straight after the redirect. A missed redirect shows as a wrong `pc_o` in that same cycle. Every such error is visible within at most four cycles of its cause, so a per-cycle comparison of all outputs against a reference model catches it near the cycle where it happens.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [1:0] {
        ACT_SEQ    = 2'd0,
        ACT_HOLD   = 2'd1,
        ACT_CALL   = 2'd2,
        ACT_BRANCH = 2'd3
    } act_e;
endpackage

// File: rtl/pcc_resolve.sv
module pcc_resolve
    import pcc_pkg::*;
#(
    parameter int NSTG     = 4,
    parameter int CALL_STG = 1,
    parameter int BR_STG   = 2
) (
    input  logic            stall_i,
    input  logic [NSTG-1:0] vld_i,
    input  logic            call_req_i,
    input  logic            br_req_i,
    output act_e            act_o,
    output logic            adv_o,
    output logic [NSTG-1:0] kill_o
);
    function automatic logic [NSTG-1:0] low_mask(input int n);
        logic [NSTG-1:0] m;
        for (int i = 0; i < NSTG; i++) m[i] = (i < n);
        return m;
    endfunction

    logic br_hit, call_hit;

    always_comb begin
        br_hit   = vld_i[BR_STG] && br_req_i;
        call_hit = vld_i[CALL_STG] && call_req_i && !stall_i && !br_hit;
        act_o    = ACT_SEQ;
        adv_o    = 1'b1;
        kill_o   = '0;
        if (br_hit) begin
            act_o  = ACT_BRANCH;
            adv_o  = !stall_i;
            kill_o = stall_i ? low_mask(BR_STG) : low_mask(BR_STG + 1);
        end else if (call_hit) begin
            act_o  = ACT_CALL;
            kill_o = low_mask(CALL_STG + 1);
        end else if (stall_i) begin
            act_o  = ACT_HOLD;
            adv_o  = 1'b0;
        end
    end
endmodule

// File: rtl/pcc_chain.sv
module pcc_chain #(
    parameter int NSTG = 4,
    parameter int AW   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    input  logic [NSTG-1:0]    kill_i,
    input  logic [AW-1:0]      in_npc_i,
    output logic [NSTG-1:0]    vld_o,
    output logic [NSTG*AW-1:0] npc_o
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] npc;
    } stg_t;

    stg_t [NSTG-1:0] st_d, st_q;

    always_comb begin
        for (int i = 0; i < NSTG; i++) begin
            if (adv_i) begin
                if (i == 0) st_d[i] = '{vld: 1'b1, npc: in_npc_i};
                else        st_d[i] = st_q[i-1];
            end else begin
                st_d[i] = st_q[i];
            end
            if (kill_i[i]) st_d[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTG; i++) st_q[i] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_out
        assign vld_o[g]             = st_q[g].vld;
        assign npc_o[g*AW +: AW]    = st_q[g].npc;
    end

    // R3: an unkilled advance moves stage 0 content into stage 1 unchanged
    p_carry_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !kill_i[1]) |=> (st_q[1] == $past(st_q[0])));
    // R7: no advance and no kill keeps every stage as it was
    p_hold_stages_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && kill_i == '0) |=> $stable(st_q));
endmodule

// File: rtl/pc_chain.sv
module pc_chain
    import pcc_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          LW       = 4,
    parameter int          NSTG     = 4,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic [LW-1:0]   fetch_len_i,
    input  logic            ex_call_i,
    input  logic [AW-1:0]   ex_target_i,
    input  logic            mem_taken_i,
    input  logic [AW-1:0]   mem_target_i,
    output logic [AW-1:0]   pc_o,
    output logic [NSTG-1:0] vld_o,
    output logic [AW-1:0]   ex_npc_o,
    output logic [AW-1:0]   wb_npc_o,
    output logic            ra_push_o,
    output logic [AW-1:0]   ra_addr_o
);
    localparam int CALL_STG = 1;
    localparam int BR_STG   = 2;
    localparam int WB_STG   = NSTG - 1;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          push;
        logic [AW-1:0] ra;
    } top_t;

    top_t s_d, s_q;
    act_e act;
    logic adv;
    logic [NSTG-1:0] kill;
    logic [NSTG*AW-1:0] npc_flat;
    logic [AW-1:0] fall_thru;

    assign fall_thru = s_q.pc + {{(AW-LW){1'b0}}, fetch_len_i};

    pcc_resolve #(.NSTG(NSTG), .CALL_STG(CALL_STG), .BR_STG(BR_STG)) u_res (
        .stall_i    (stall_i),
        .vld_i      (vld_o),
        .call_req_i (ex_call_i),
        .br_req_i   (mem_taken_i),
        .act_o      (act),
        .adv_o      (adv),
        .kill_o     (kill)
    );

    pcc_chain #(.NSTG(NSTG), .AW(AW)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv),
        .kill_i   (kill),
        .in_npc_i (fall_thru),
        .vld_o    (vld_o),
        .npc_o    (npc_flat)
    );

    always_comb begin
        s_d      = s_q;
        s_d.push = 1'b0;
        case (act)
            ACT_SEQ:    s_d.pc = fall_thru;
            ACT_CALL: begin
                s_d.pc   = ex_target_i;
                s_d.push = 1'b1;
                s_d.ra   = npc_flat[CALL_STG*AW +: AW];
            end
            ACT_BRANCH: s_d.pc = mem_target_i;
            default:    s_d.pc = s_q.pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pc   <= RESET_PC[AW-1:0];
            s_q.push <= 1'b0;
            s_q.ra   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o      = s_q.pc;
    assign ra_push_o = s_q.push;
    assign ra_addr_o = s_q.ra;
    assign ex_npc_o  = npc_flat[CALL_STG*AW +: AW];
    assign wb_npc_o  = npc_flat[WB_STG*AW +: AW];

    // R4: a push strobe lasts a single cycle
    p_push_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ra_push_o |=> !ra_push_o);
    // R4: the push coincides with fetch at the call target
    p_push_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ra_push_o |-> (pc_o == $past(ex_target_i)));
    // R4: the pushed address is what execute carried before the edge
    p_push_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ra_push_o |-> (ra_addr_o == $past(ex_npc_o)));
    // R5: younger stages are empty and the call sits in memory
    p_push_squash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ra_push_o |-> (vld_o[1:0] == 2'b00 && vld_o[2]));
    // R7: stall without a branch freezes the PC
    p_stall_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !(vld_o[BR_STG] && mem_taken_i)) |=> $stable(pc_o));
    // R8: branch during stall clears decode and execute
    p_stall_br_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && vld_o[BR_STG] && mem_taken_i) |=> (vld_o[1:0] == 2'b00));
    // R9: a call request with an empty execute stage pushes nothing
    p_idle_call_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_call_i && !vld_o[CALL_STG]) |=> !ra_push_o);
endmodule

// File: tb/sim_pc_chain.sv
module sim_pc_chain;
    localparam int AW = 16;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall_i = 1'b0;
    logic [LW-1:0] fetch_len_i = '0;
    logic ex_call_i = 1'b0;
    logic [AW-1:0] ex_target_i = '0;
    logic mem_taken_i = 1'b0;
    logic [AW-1:0] mem_target_i = '0;
    logic [AW-1:0] pc_o;
    logic [3:0] vld_o;
    logic [AW-1:0] ex_npc_o, wb_npc_o, ra_addr_o;
    logic ra_push_o;

    always #2 clk = ~clk;

    pc_chain #(.AW(AW), .LW(LW), .NSTG(4), .RESET_PC(16'h0012)) u0 (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .fetch_len_i(fetch_len_i),
        .ex_call_i(ex_call_i), .ex_target_i(ex_target_i),
        .mem_taken_i(mem_taken_i), .mem_target_i(mem_target_i),
        .pc_o(pc_o), .vld_o(vld_o), .ex_npc_o(ex_npc_o), .wb_npc_o(wb_npc_o),
        .ra_push_o(ra_push_o), .ra_addr_o(ra_addr_o)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [AW-1:0] m_pc;
    logic [3:0]    m_v;
    logic [AW-1:0] m_n [4];
    logic          m_push;
    logic [AW-1:0] m_ra;

    task automatic chk(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "pc", pc_o, m_pc);
        chk(tag, "vld", {12'd0, vld_o}, {12'd0, m_v});
        chk(tag, "push", {15'd0, ra_push_o}, {15'd0, m_push});
        if (m_push) chk(tag, "ra", ra_addr_o, m_ra);
        if (m_v[1]) chk(tag, "ex_npc", ex_npc_o, m_n[1]);
        if (m_v[3]) chk(tag, "wb_npc", wb_npc_o, m_n[3]);
    endtask

    // reference next state derived from the requirements
    task automatic model_step();
        bit brh, calh;
        brh  = m_v[2] && mem_taken_i;
        calh = m_v[1] && ex_call_i && !stall_i && !brh;
        m_push = 1'b0;
        if (brh) begin
            m_pc = mem_target_i;
            if (stall_i) begin
                m_v[0] = 1'b0; m_v[1] = 1'b0;
            end else begin
                m_v[3] = m_v[2]; m_n[3] = m_n[2];
                m_v[2] = 1'b0; m_v[1] = 1'b0; m_v[0] = 1'b0;
            end
        end else if (calh) begin
            m_push = 1'b1;
            m_ra   = m_n[1];
            m_pc   = ex_target_i;
            m_v[3] = m_v[2]; m_n[3] = m_n[2];
            m_v[2] = 1'b1;   m_n[2] = m_n[1];
            m_v[1] = 1'b0;   m_v[0] = 1'b0;
        end else if (!stall_i) begin
            for (int i = 3; i > 0; i--) begin
                m_v[i] = m_v[i-1]; m_n[i] = m_n[i-1];
            end
            m_v[0] = 1'b1;
            m_n[0] = m_pc + {12'd0, fetch_len_i};
            m_pc   = m_n[0];
        end
    endtask

    task automatic step(input bit st, input int len, input bit cl, input logic [AW-1:0] ct,
                        input bit br, input logic [AW-1:0] bt, input string tag);
        stall_i = st; fetch_len_i = LW'(len); ex_call_i = cl; ex_target_i = ct;
        mem_taken_i = br; mem_target_i = bt;
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd2024));
        m_pc = 16'h0012; m_v = '0; m_push = 0; m_ra = '0;
        for (int i = 0; i < 4; i++) m_n[i] = '0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        // call request while execute is empty: ignored
        step(0, 2, 1, 16'h0200, 1, 16'h0300, "R9");
        step(0, 2, 0, 16'h0000, 0, 16'h0000, "R3");
        // call at 0x12 to 0x100 reaches execute; pushes 0x14, squashes 0x14/0x16
        step(0, 2, 1, 16'h0100, 0, 16'h0000, "R4 R5");
        chk("R4", "ra_0x14", ra_addr_o, 16'h0014);
        chk("R5", "vld_after_call", {12'd0, vld_o}, 16'h0004);
        step(0, 3, 0, 16'h0000, 0, 16'h0000, "R10");
        chk("R10", "pc_len3", pc_o, 16'h0103);
        step(0, 5, 0, 16'h0000, 0, 16'h0000, "R2");
        step(0, 7, 0, 16'h0000, 0, 16'h0000, "R3");
        // stalled call in execute waits
        step(1, 1, 1, 16'h0400, 0, 16'h0000, "R7");
        step(1, 1, 1, 16'h0400, 0, 16'h0000, "R7");
        step(0, 1, 0, 16'h0000, 0, 16'h0000, "R2");
        step(0, 4, 0, 16'h0000, 0, 16'h0000, "R3");
        // branch in memory during stall
        step(1, 2, 0, 16'h0000, 1, 16'h0800, "R8");
        step(0, 2, 0, 16'h0000, 0, 16'h0000, "R2");
        step(0, 2, 0, 16'h0000, 0, 16'h0000, "R2");
        step(0, 2, 0, 16'h0000, 0, 16'h0000, "R2");
        // branch in memory beats call in execute
        step(0, 2, 1, 16'h0A00, 1, 16'h0C00, "R6");
        for (int k = 0; k < 3000; k++) begin
            step(($urandom_range(0, 9) < 2), $urandom_range(1, 15),
                 ($urandom_range(0, 9) < 3), 16'($urandom),
                 ($urandom_range(0, 9) < 2), 16'($urandom), "R2 R3 R4");
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule